// File: doc/BRIEF.md
# Per-Core Interrupt Acknowledge Unit

This unit sits between an interrupt router and one CPU core. It watches the vector of requests that the router has already enabled and steered to this core. When any request appears while the unit is idle, it raises the core's interrupt line and waits for the core to ask which source fired. A source read picks the lowest-numbered request that is still present, hands its number back and makes that source the active interrupt. If nothing is requesting by the time of the read, the read returns the all-ones spurious code and the unit goes straight back to idle.

While a source is active, the line stays low and new requests wait. The core closes the interrupt with an end-of-interrupt write that names the returned number. A disable write naming that same number also closes it. Every operation carries the number of the core that issued it. Operations issued by any other core are discarded, so only the receiving core can complete its own interrupt. An end-of-interrupt that is out of place or names the wrong source is dropped and sets a sticky error flag.

Top module: `irq_ack_unit`

## Requirements
- R1: While idle, any set bit of `reqVec` moves the unit to pending; `irqLine` is high from the next cycle.
- R2: `irqLine` is high exactly while the unit is pending. It stays high if every request is withdrawn before the source read.
- R3: A local source read (`opCode` 1) while pending with requests present gives `rdValid` high and `rdData` equal to the lowest set index of `reqVec` on the next cycle. The unit becomes active: `irqLine` stays low and is not raised again while active, even with requests present.
- R4: A local source read while pending with no requests present returns `rdData` all ones, which is the spurious code, and goes back to idle. No end-of-interrupt is needed afterwards.
- R5: A local end-of-interrupt (`opCode` 2) in active whose `opId` equals the returned number returns the unit to idle. `irqLine` rises one cycle later if requests are present.
- R6: A local disable (`opCode` 3) in active whose `opId` equals the returned number returns the unit to idle. A disable that names another number changes nothing.
- R7: An end-of-interrupt while idle or pending, or one in active that names another number, changes no state and sets `errFlag`.
- R8: A local source read while idle or active returns `rdData` all ones with `rdValid` high and changes no state.
- R9: An operation whose `opCore` differs from the `CORE_ID` parameter has no effect on the state, `rdValid`, `rdData` or `errFlag`.
- R10: Reset clears `irqLine`, `rdValid`, `rdData` and `errFlag` and enters idle. Once set, `errFlag` stays set until reset.
- R11: With `opValid` low, or with `opCode` 0, an operation does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqVec | input | NUM_SRC | Routed, enabled requests for this core |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 2 | 0 none, 1 source read, 2 end-of-interrupt, 3 disable |
| opCore | input | CORE_W | Number of the core issuing the operation |
| opId | input | DATA_W | Source number named by an end-of-interrupt or disable |
| irqLine | output | 1 | Interrupt request line to the core |
| rdValid | output | 1 | One-cycle pulse: `rdData` holds a source read result |
| rdData | output | DATA_W | Result of the last source read; all ones means spurious |
| errFlag | output | 1 | Sticky flag for a misplaced or mismatched end-of-interrupt |

## Verification
The bench targets a request that is withdrawn between the raise of the line and the read. A design that latched the winner at raise time would return a stale number there instead of the spurious code. It checks that a disable naming a different source leaves the unit active, and that an end-of-interrupt or disable from another core is discarded. A design that did not compare the core number would complete someone else's interrupt, and the line would rise again too early. It also covers reads in idle and in active, which must not disturb the state, and the arbitration extremes with all requests set and with only the top source set. An encoder that picked the wrong end returns the wrong index in those cases. Finally, it checks that the error flag stays set across later legal traffic and is cleared only by reset.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2
  } ackState_t;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_READ = 2'd1,
    OP_EOI  = 2'd2,
    OP_DIS  = 2'd3
  } ackOp_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeWinner;    // load the arbitration winner as active id and read result
    logic takeSpurious;  // present the spurious code as read result
    logic flagError;     // set the sticky error flag
  } ackStrobe_t;

endpackage

// File: rtl/irq_ack_datapath.sv
module irq_ack_datapath
  import irq_ack_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] reqVec,
  input  logic [DATA_W-1:0]  opId,
  input  ackStrobe_t         strobe,
  output logic               anyReq,
  output logic               idMatch,
  output logic               rdValid,
  output logic [DATA_W-1:0]  rdData,
  output logic               errFlag
);

  logic [DATA_W-1:0] winId;
  logic [DATA_W-1:0] activeId;
  logic              found;

  // Lowest-index arbitration
  always_comb begin
    winId = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reqVec[i] && !found) begin
        winId = DATA_W'(i);
        found = 1'b1;
      end
    end
  end

  assign anyReq  = found;
  assign idMatch = (opId == activeId);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeId <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
      errFlag  <= 1'b0;
    end else begin
      rdValid <= strobe.takeWinner | strobe.takeSpurious;
      if (strobe.takeWinner) begin
        activeId <= winId;
        rdData   <= winId;
      end else if (strobe.takeSpurious) begin
        rdData <= '1;
      end
      if (strobe.flagError) begin
        errFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int CORE_W  = 2,
  parameter int CORE_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [1:0]        opCode,
  input  logic [CORE_W-1:0] opCore,
  input  logic              anyReq,
  input  logic              idMatch,
  output ackStrobe_t        strobe,
  output logic              irqLine
);

  ackState_t state;
  ackState_t stateNxt;

  logic ownOp;
  logic isRead;
  logic isEoi;
  logic isDis;

  assign ownOp  = opValid && (opCore == CORE_W'(CORE_ID));
  assign isRead = ownOp && (opCode == OP_READ);
  assign isEoi  = ownOp && (opCode == OP_EOI);
  assign isDis  = ownOp && (opCode == OP_DIS);

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (isRead) strobe.takeSpurious = 1'b1;
        if (isEoi)  strobe.flagError    = 1'b1;
        if (anyReq) stateNxt = ST_PEND;
      end
      ST_PEND: begin
        if (isRead) begin
          if (anyReq) begin
            strobe.takeWinner = 1'b1;
            stateNxt = ST_ACT;
          end else begin
            strobe.takeSpurious = 1'b1;
            stateNxt = ST_IDLE;
          end
        end
        if (isEoi) strobe.flagError = 1'b1;
      end
      ST_ACT: begin
        if (isRead) strobe.takeSpurious = 1'b1;
        if (isEoi) begin
          if (idMatch) stateNxt = ST_IDLE;
          else         strobe.flagError = 1'b1;
        end
        if (isDis && idMatch) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  assign irqLine = (state == ST_PEND);

endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irq_ack_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int NUM_CORES = 4,
  parameter int CORE_ID   = 0,
  localparam int DATA_W   = $clog2(NUM_SRC) + 1,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] reqVec,
  input  logic               opValid,
  input  logic [1:0]         opCode,
  input  logic [CORE_W-1:0]  opCore,
  input  logic [DATA_W-1:0]  opId,
  output logic               irqLine,
  output logic               rdValid,
  output logic [DATA_W-1:0]  rdData,
  output logic               errFlag
);

  ackStrobe_t strobe;
  logic       anyReq;
  logic       idMatch;

  irq_ack_ctrl #(
    .CORE_W (CORE_W),
    .CORE_ID(CORE_ID)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opValid(opValid),
    .opCode (opCode),
    .opCore (opCore),
    .anyReq (anyReq),
    .idMatch(idMatch),
    .strobe (strobe),
    .irqLine(irqLine)
  );

  irq_ack_datapath #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .reqVec (reqVec),
    .opId   (opId),
    .strobe (strobe),
    .anyReq (anyReq),
    .idMatch(idMatch),
    .rdValid(rdValid),
    .rdData (rdData),
    .errFlag(errFlag)
  );

endmodule

// File: rtl/irq_ack_checker.sv
module irq_ack_checker #(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 4,
  parameter int CORE_W  = 2,
  parameter int CORE_ID = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] reqVec,
  input logic               opValid,
  input logic [1:0]         opCode,
  input logic [CORE_W-1:0]  opCore,
  input logic               irqLine,
  input logic               rdValid,
  input logic [DATA_W-1:0]  rdData,
  input logic               errFlag
);

  logic ownOp;
  logic ownRead;
  logic ownEoi;
  assign ownOp   = opValid && (opCore == CORE_W'(CORE_ID));
  assign ownRead = ownOp && (opCode == 2'd1);
  assign ownEoi  = ownOp && (opCode == 2'd2);

  // R1
  line_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqLine) |-> $past(|reqVec));

  // R2
  line_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irqLine) |-> $past(ownRead));

  // R3
  winner_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ownRead && irqLine && (|reqVec)) |=> (rdValid && (rdData < DATA_W'(NUM_SRC)) && !irqLine));

  // R4
  spurious_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ownRead && irqLine && !(|reqVec)) |=> (rdValid && (&rdData) && !irqLine));

  // R8
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ownRead && !irqLine) |=> (rdValid && (&rdData)));

  // R7
  pend_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ownEoi && irqLine) |=> (errFlag && irqLine));

  // R9
  foreign_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && (opCore != CORE_W'(CORE_ID))) |=> !rdValid);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |=> errFlag);

endmodule

bind irq_ack_unit irq_ack_checker #(
  .NUM_SRC(NUM_SRC),
  .DATA_W (DATA_W),
  .CORE_W (CORE_W),
  .CORE_ID(CORE_ID)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .reqVec (reqVec),
  .opValid(opValid),
  .opCode (opCode),
  .opCore (opCore),
  .irqLine(irqLine),
  .rdValid(rdValid),
  .rdData (rdData),
  .errFlag(errFlag)
);

// File: tb/irq_ack_unit_bench.sv
module irq_ack_unit_bench;

  localparam int NSRC  = 8;
  localparam int NCORE = 4;
  localparam int MYID  = 2;
  localparam int NVEC  = 22;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] reqVec;
  logic       opValid;
  logic [1:0] opCode;
  logic [1:0] opCore;
  logic [3:0] opId;
  logic       irqLine;
  logic       rdValid;
  logic [3:0] rdData;
  logic       errFlag;

  int testsRun  = 0;
  int testsFail = 0;
  bit finished  = 1'b0;

  always #10 clk = ~clk;

  irq_ack_unit #(
    .NUM_SRC  (NSRC),
    .NUM_CORES(NCORE),
    .CORE_ID  (MYID)
  ) u_irq_ack_unit (
    .clk    (clk),
    .rst_n  (rst_n),
    .reqVec (reqVec),
    .opValid(opValid),
    .opCode (opCode),
    .opCore (opCore),
    .opId   (opId),
    .irqLine(irqLine),
    .rdValid(rdValid),
    .rdData (rdData),
    .errFlag(errFlag)
  );

  typedef struct packed {
    logic [7:0] req;
    logic       v;
    logic [1:0] op;
    logic [1:0] core;
    logic [3:0] id;
    logic       eIrq;
    logic       eRv;
    logic [3:0] eData;
    logic       eErr;
    logic [3:0] rq;
  } vec_t;

  // opCode: 0 none, 1 read, 2 end-of-interrupt, 3 disable; own core is 2
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 1'b0, 2'd0, 2'd2, 4'd0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd11}, // R11 idle nop
    '{8'h00, 1'b1, 2'd1, 2'd2, 4'd0, 1'b0, 1'b1, 4'd15, 1'b0, 4'd8},  // R8 read in idle
    '{8'h24, 1'b0, 2'd0, 2'd2, 4'd0, 1'b1, 1'b0, 4'd15, 1'b0, 4'd1},  // R1 raise
    '{8'h24, 1'b1, 2'd1, 2'd2, 4'd0, 1'b0, 1'b1, 4'd2,  1'b0, 4'd3},  // R3 winner 2
    '{8'h24, 1'b1, 2'd2, 2'd1, 4'd2, 1'b0, 1'b0, 4'd2,  1'b0, 4'd9},  // R9 foreign eoi
    '{8'h24, 1'b1, 2'd1, 2'd2, 4'd0, 1'b0, 1'b1, 4'd15, 1'b0, 4'd8},  // R8 read in active
    '{8'h24, 1'b1, 2'd3, 2'd2, 4'd5, 1'b0, 1'b0, 4'd15, 1'b0, 4'd6},  // R6 other-id disable
    '{8'h24, 1'b1, 2'd2, 2'd2, 4'd2, 1'b0, 1'b0, 4'd15, 1'b0, 4'd5},  // R5 eoi
    '{8'h24, 1'b0, 2'd0, 2'd2, 4'd0, 1'b1, 1'b0, 4'd15, 1'b0, 4'd5},  // R5 re-raise
    '{8'h20, 1'b1, 2'd1, 2'd2, 4'd0, 1'b0, 1'b1, 4'd5,  1'b0, 4'd3},  // R3 winner 5
    '{8'h20, 1'b1, 2'd3, 2'd2, 4'd5, 1'b0, 1'b0, 4'd5,  1'b0, 4'd6},  // R6 disable ends
    '{8'h00, 1'b0, 2'd0, 2'd2, 4'd0, 1'b0, 1'b0, 4'd5,  1'b0, 4'd6},  // R6 idle
    '{8'h80, 1'b0, 2'd0, 2'd2, 4'd0, 1'b1, 1'b0, 4'd5,  1'b0, 4'd1},  // R1 raise
    '{8'h00, 1'b0, 2'd0, 2'd2, 4'd0, 1'b1, 1'b0, 4'd5,  1'b0, 4'd2},  // R2 withdrawn
    '{8'h00, 1'b1, 2'd1, 2'd2, 4'd0, 1'b0, 1'b1, 4'd15, 1'b0, 4'd4},  // R4 spurious
    '{8'h01, 1'b1, 2'd1, 2'd1, 4'd0, 1'b1, 1'b0, 4'd15, 1'b0, 4'd9},  // R9 foreign read
    '{8'h01, 1'b1, 2'd1, 2'd2, 4'd0, 1'b0, 1'b1, 4'd0,  1'b0, 4'd3},  // R3 winner 0
    '{8'h01, 1'b0, 2'd1, 2'd2, 4'd0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd11}, // R11 valid low
    '{8'h01, 1'b1, 2'd2, 2'd2, 4'd1, 1'b0, 1'b0, 4'd0,  1'b1, 4'd7},  // R7 mismatch eoi
    '{8'h01, 1'b1, 2'd2, 2'd2, 4'd0, 1'b0, 1'b0, 4'd0,  1'b1, 4'd10}, // R10 sticky, eoi ok
    '{8'h01, 1'b0, 2'd0, 2'd2, 4'd0, 1'b1, 1'b0, 4'd0,  1'b1, 4'd5},  // R5 re-raise
    '{8'h01, 1'b1, 2'd2, 2'd2, 4'd0, 1'b1, 1'b0, 4'd0,  1'b1, 4'd7}   // R7 eoi in pending
  };

  task automatic checkOut(input logic eIrq, input logic eRv, input logic [3:0] eData,
                          input logic eErr, input int rq);
    testsRun++;
    if (irqLine !== eIrq || rdValid !== eRv || rdData !== eData || errFlag !== eErr) begin
      testsFail++;
      $display("FAIL R%0d: irq/rv/data/err actual %b/%b/%0d/%b expected %b/%b/%0d/%b",
               rq, irqLine, rdValid, rdData, errFlag, eIrq, eRv, eData, eErr);
    end
  endtask

  task automatic step(input logic [7:0] r, input logic v, input logic [1:0] op,
                      input logic [1:0] c, input logic [3:0] id,
                      input logic eIrq, input logic eRv, input logic [3:0] eData,
                      input logic eErr, input int rq);
    reqVec = r; opValid = v; opCode = op; opCore = c; opId = id;
    @(posedge clk);
    @(negedge clk);
    checkOut(eIrq, eRv, eData, eErr, rq);
  endtask

  task automatic doReset();
    rst_n = 1'b0; reqVec = '0; opValid = 1'b0; opCode = '0; opCore = '0; opId = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    doReset();
    checkOut(1'b0, 1'b0, 4'd0, 1'b0, 10); // R10 reset state

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].req, VECS[i].v, VECS[i].op, VECS[i].core, VECS[i].id,
           VECS[i].eIrq, VECS[i].eRv, VECS[i].eData, VECS[i].eErr, int'(VECS[i].rq));
    end

    // R10: reset clears the sticky flag
    doReset();
    checkOut(1'b0, 1'b0, 4'd0, 1'b0, 10);

    // R3: all sources set, lowest wins
    step(8'hFF, 1'b0, 2'd0, 2'd2, 4'd0, 1'b1, 1'b0, 4'd0, 1'b0, 1);
    step(8'hFF, 1'b1, 2'd1, 2'd2, 4'd0, 1'b0, 1'b1, 4'd0, 1'b0, 3);
    // R9: disable from another core of the active source is ignored
    step(8'hFF, 1'b1, 2'd3, 2'd3, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 9);
    step(8'hFF, 1'b0, 2'd0, 2'd2, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 9);
    // R5: own eoi ends it
    step(8'h80, 1'b1, 2'd2, 2'd2, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 5);
    // R3: only the top source set
    step(8'h80, 1'b0, 2'd0, 2'd2, 4'd0, 1'b1, 1'b0, 4'd0, 1'b0, 1);
    step(8'h80, 1'b1, 2'd1, 2'd2, 4'd0, 1'b0, 1'b1, 4'd7, 1'b0, 3);
    step(8'h80, 1'b1, 2'd2, 2'd2, 4'd7, 1'b0, 1'b0, 4'd7, 1'b0, 5);
    // R7: eoi while idle sets the flag, no state change
    step(8'h00, 1'b1, 2'd2, 2'd2, 4'd7, 1'b0, 1'b0, 4'd7, 1'b1, 7);
    step(8'h00, 1'b0, 2'd0, 2'd2, 4'd0, 1'b0, 1'b0, 4'd7, 1'b1, 10);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

endmodule